// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sequences conversions for a multi-channel analog-to-digital converter. A 16-bit synchronous register port sets it up. A channel mask selects up to 32 inputs. Channels 0 to 15 live in a low select register. Channels 16 and up live in a high select register, and that register exists only when the block is built with more than 16 channels.

Software sets the enable bit and writes the start bit. The block then converts one chosen channel or walks the mask. It can walk the mask once, or again and again until software stops it. The converter is reached through a simple request/done port: the block presents a channel index for one cycle, and later receives a 10-bit sample with a done strobe.

Every sample lands in that channel's data register and marks it as fresh. At the end of each pass the block raises a sticky event bit. An interrupt follows that bit when its enable is set.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `conv_req` is low.
- R2: The low select register at byte offset 0x008 holds the mask bits of channels 0–15. The high select register at 0x00A holds channels 16 and up, in its bits [NUM_CH-17:0]. Mask bits for channels at or above NUM_CH read 0. When NUM_CH is 16 or less, the high register reads 0 and writes to it are ignored.
- R3: With CFG (offset 0x000) bit 4 = 1 (scan), a write to CFG with bit 0 (enable) and bit 1 (start) both set converts every selected channel exactly once, in ascending index order. Each channel gets one single-cycle `conv_req`. After a done, the next request or the end of the pass follows in the very next cycle, with no slots spent on unselected channels.
- R4: With CFG bit 4 = 0 (single), a start converts only the channel whose index is in register 0x004 bits [4:0]. If that index is NUM_CH or more, the pass completes with no conversion.
- R5: The data register of channel c sits at 0x040 + 2·c. Each conversion writes the sample into bits [9:0] and sets bit 15 (new).
- R6: Reading a data register clears its new bit and leaves bits [9:0] unchanged.
- R7: Status register 0x002 bit 0 is set at the end of each pass. Writing 1 to it clears it, writing 0 leaves it, and a set in the same cycle as a clear wins. Bit 1 reads 1 while a pass is running.
- R8: `irq` is high exactly while status bit 0 and CFG bit 7 are both 1.
- R9: A scan start with an all-zero mask completes the pass at once: the event is set and no conversion is requested.
- R10: With CFG bit 6 (repeat) set, a finished pass reloads the current mask and runs again without a new start. CFG reads back its stored bits 0, 4, 6 and 7, and bits 1 and 11 always read 0.
- R11: Writing 1 to CFG bit 11 (stop), or writing CFG with bit 0 = 0, aborts the pass. Busy drops, no event is raised, and a sample returned for the aborted request is not stored. A start written with the enable bit at 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | End-of-pass interrupt |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | $clog2(NUM_CH) | Channel index of the request |
| conv_done | input | 1 | Converter sample valid |
| conv_data | input | RES_W | Converter sample |

## Verification
The bench builds two instances.

The first uses NUM_CH = 26. This reaches the split mask across both select registers, the masking of the unused high bits, channel 25 at the top of the walk, and single-channel indices beyond the last channel.

The second uses NUM_CH = 12, where the high select register must be absent. There the low register also drops the bits for channels 12–15.

The converter model answers with random latency during normal passes. It switches to a fixed long latency so that stop and disable land while a request is outstanding.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // byte offsets
  localparam logic [7:0] OFS_CFG    = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h02;
  localparam logic [7:0] OFS_ONE    = 8'h04;
  localparam logic [7:0] OFS_SEL_LO = 8'h08;
  localparam logic [7:0] OFS_SEL_HI = 8'h0A;

  // control word bit positions
  localparam int CFG_EN   = 0;
  localparam int CFG_GO   = 1;
  localparam int CFG_SCAN = 4;
  localparam int CFG_REP  = 6;
  localparam int CFG_IE   = 7;
  localparam int CFG_HALT = 11;

  localparam int STAT_EVT  = 0;
  localparam int STAT_BUSY = 1;
  localparam int DAT_NEW   = 15;

  localparam int SEL_W = 16;

endpackage

// File: rtl/adc_seq_pick.sv
// Lowest-set-bit finder over the pending channel mask.
module adc_seq_pick #(
  parameter  int NUM_CH = 26,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  output logic [CH_W-1:0]   idx,
  output logic              any
);

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) idx = CH_W'(i);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH = 26,
  parameter  int RES_W  = 10,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              cfg_en,
  output logic              cfg_scan,
  output logic              cfg_rep,
  output logic              cfg_ie,
  output logic [NUM_CH-1:0] sel_mask,
  output logic [4:0]        one_idx,
  output logic              start_q,
  output logic              stop_q,
  input  logic              cyc_done,
  input  logic              res_we,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [RES_W-1:0]  res_val,
  input  logic              busy,
  output logic              irq
);

  logic cfg_hit, stat_hit, one_hit, lo_hit, hi_hit, dat_hit;
  logic [4:0] dat_idx;

  assign cfg_hit  = (addr == OFS_CFG);
  assign stat_hit = (addr == OFS_STAT);
  assign one_hit  = (addr == OFS_ONE);
  assign lo_hit   = (addr == OFS_SEL_LO);
  assign hi_hit   = (addr == OFS_SEL_HI);
  assign dat_idx  = addr[5:1];
  assign dat_hit  = (addr[7:6] == 2'b01) && !addr[0] && (int'(dat_idx) < NUM_CH);

  // control and status state
  logic en_d, scan_d, rep_d, ie_d, start_d, stop_d, evt_d, evt_q;
  logic [4:0]        one_d;
  logic [NUM_CH-1:0] sel_d;

  always_comb begin
    en_d   = cfg_en;
    scan_d = cfg_scan;
    rep_d  = cfg_rep;
    ie_d   = cfg_ie;
    if (wr_en && cfg_hit) begin
      en_d   = wdata[CFG_EN];
      scan_d = wdata[CFG_SCAN];
      rep_d  = wdata[CFG_REP];
      ie_d   = wdata[CFG_IE];
    end
    start_d = wr_en && cfg_hit && wdata[CFG_GO] && wdata[CFG_EN];
    stop_d  = wr_en && cfg_hit && wdata[CFG_HALT];
    one_d   = (wr_en && one_hit) ? wdata[4:0] : one_idx;
    evt_d   = evt_q;
    if (wr_en && stat_hit && wdata[STAT_EVT]) evt_d = 1'b0;
    if (cyc_done) evt_d = 1'b1;
    sel_d = sel_mask;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c < SEL_W) begin
        if (wr_en && lo_hit) sel_d[c] = wdata[c % SEL_W];
      end else begin
        if (wr_en && hi_hit) sel_d[c] = wdata[c % SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_scan <= 1'b0;
      cfg_rep  <= 1'b0;
      cfg_ie   <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      one_idx  <= '0;
      evt_q    <= 1'b0;
      sel_mask <= '0;
    end else begin
      cfg_en   <= en_d;
      cfg_scan <= scan_d;
      cfg_rep  <= rep_d;
      cfg_ie   <= ie_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
      one_idx  <= one_d;
      evt_q    <= evt_d;
      sel_mask <= sel_d;
    end
  end

  assign irq = evt_q & cfg_ie;

  // per-channel result storage
  logic [NUM_CH*RES_W-1:0] val_flat;
  logic [NUM_CH-1:0]       new_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             ch_wr, ch_clr, new_q;
    logic [RES_W-1:0] val_q;

    assign ch_wr  = res_we && (res_ch == CH_W'(c));
    assign ch_clr = rd_en && dat_hit && (dat_idx == 5'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        new_q <= 1'b0;
      end else begin
        if (ch_wr) val_q <= res_val;
        if (ch_wr)       new_q <= 1'b1;
        else if (ch_clr) new_q <= 1'b0;
      end
    end

    assign val_flat[c*RES_W +: RES_W] = val_q;
    assign new_vec[c] = new_q;
  end

  // read path
  logic [15:0] rd_v;
  logic [31:0] sel_pad;

  always_comb begin
    sel_pad = '0;
    sel_pad[NUM_CH-1:0] = sel_mask;
    rd_v = '0;
    if (cfg_hit) begin
      rd_v[CFG_EN]   = cfg_en;
      rd_v[CFG_SCAN] = cfg_scan;
      rd_v[CFG_REP]  = cfg_rep;
      rd_v[CFG_IE]   = cfg_ie;
    end else if (stat_hit) begin
      rd_v[STAT_EVT]  = evt_q;
      rd_v[STAT_BUSY] = busy;
    end else if (one_hit) begin
      rd_v[4:0] = one_idx;
    end else if (lo_hit) begin
      rd_v = sel_pad[15:0];
    end else if (hi_hit) begin
      rd_v = sel_pad[31:16];
    end else if (dat_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (dat_idx == 5'(c)) begin
          rd_v[RES_W-1:0] = val_flat[c*RES_W +: RES_W];
          rd_v[DAT_NEW]   = new_vec[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_v;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH = 26,
  parameter  int RES_W  = 10,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_q,
  input  logic              abort,
  input  logic              cfg_scan,
  input  logic              cfg_rep,
  input  logic [NUM_CH-1:0] sel_mask,
  input  logic [4:0]        one_idx,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              res_we,
  output logic [CH_W-1:0]   res_ch,
  output logic [RES_W-1:0]  res_val,
  output logic              cyc_done,
  output logic              busy
);

  seq_state_e        st_q, st_d;
  logic [NUM_CH-1:0] pend_q, pend_d, one_hot, load_mask;
  logic [CH_W-1:0]   cur_q, cur_d, lo_idx;
  logic              lo_any;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_one
    assign one_hot[c] = (one_idx == 5'(c));
  end

  assign load_mask = cfg_scan ? sel_mask : one_hot;

  adc_seq_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask (pend_q),
    .idx  (lo_idx),
    .any  (lo_any)
  );

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    cur_d    = cur_q;
    conv_req = 1'b0;
    res_we   = 1'b0;
    cyc_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_q && !abort) begin
          pend_d = load_mask;
          st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (abort) begin
          st_d = ST_IDLE;
        end else if (!lo_any) begin
          cyc_done = 1'b1;
          if (cfg_rep && (|load_mask)) pend_d = load_mask;
          else                         st_d   = ST_IDLE;
        end else begin
          conv_req = 1'b1;
          cur_d    = lo_idx;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (abort) begin
          st_d = ST_IDLE;
        end else if (conv_done) begin
          res_we        = 1'b1;
          pend_d[cur_q] = 1'b0;
          st_d          = ST_RUN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cur_q  <= cur_d;
    end
  end

  assign conv_ch = lo_idx;
  assign res_ch  = cur_q;
  assign res_val = conv_data;
  assign busy    = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter  int NUM_CH = 26,
  parameter  int RES_W  = 10,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             irq,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data
);

  logic              cfg_en, cfg_scan, cfg_rep, cfg_ie;
  logic              start_q, stop_q, abort, busy, cyc_done, res_we;
  logic [NUM_CH-1:0] sel_mask;
  logic [4:0]        one_idx;
  logic [CH_W-1:0]   res_ch;
  logic [RES_W-1:0]  res_val;

  assign abort = stop_q | ~cfg_en;

  adc_seq_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .cfg_en   (cfg_en),
    .cfg_scan (cfg_scan),
    .cfg_rep  (cfg_rep),
    .cfg_ie   (cfg_ie),
    .sel_mask (sel_mask),
    .one_idx  (one_idx),
    .start_q  (start_q),
    .stop_q   (stop_q),
    .cyc_done (cyc_done),
    .res_we   (res_we),
    .res_ch   (res_ch),
    .res_val  (res_val),
    .busy     (busy),
    .irq      (irq)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_q   (start_q),
    .abort     (abort),
    .cfg_scan  (cfg_scan),
    .cfg_rep   (cfg_rep),
    .sel_mask  (sel_mask),
    .one_idx   (one_idx),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .res_we    (res_we),
    .res_ch    (res_ch),
    .res_val   (res_val),
    .cyc_done  (cyc_done),
    .busy      (busy)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter  int NUM_CH = 26,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_req,
  input logic [CH_W-1:0] conv_ch,
  input logic            res_we,
  input logic            cyc_done,
  input logic            abort,
  input logic            busy,
  input logic            irq,
  input logic            cfg_ie
);

  logic            in_cyc_q;
  logic [CH_W-1:0] last_ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc_q  <= 1'b0;
      last_ch_q <= '0;
    end else if (cyc_done || !busy) begin
      in_cyc_q  <= 1'b0;
    end else if (conv_req) begin
      in_cyc_q  <= 1'b1;
      last_ch_q <= conv_ch;
    end
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && in_cyc_q) |-> (conv_ch > last_ch_q));

  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (conv_req || cyc_done || abort));

  p_ch_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (int'(conv_ch) < NUM_CH));

  p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_ie);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!res_we && !cyc_done && !conv_req));

endmodule

bind adc_seq_top adc_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .conv_req (conv_req),
  .conv_ch  (conv_ch),
  .res_we   (res_we),
  .cyc_done (cyc_done),
  .abort    (abort),
  .busy     (busy),
  .irq      (irq),
  .cfg_ie   (cfg_ie)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NA = 26;
  localparam int NB = 12;
  localparam logic [15:0] C_EN = 16'h0001, C_GO = 16'h0002, C_SCAN = 16'h0010,
                          C_REP = 16'h0040, C_IE = 16'h0080, C_HALT = 16'h0800;
  localparam logic [31:0] FULL_A = (32'd1 << NA) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        a_wr = 0, a_rd = 0, a_done = 0, a_irq, a_req;
  logic [7:0]  a_addr = 0;
  logic [15:0] a_wdata = 0, a_rdata;
  logic [4:0]  a_ch;
  logic [9:0]  a_data = 0;

  logic        b_wr = 0, b_rd = 0, b_irq, b_req;
  logic [7:0]  b_addr = 0;
  logic [15:0] b_wdata = 0, b_rdata;
  logic [3:0]  b_ch;

  adc_seq_top #(.NUM_CH(NA)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq(a_irq), .conv_req(a_req),
    .conv_ch(a_ch), .conv_done(a_done), .conv_data(a_data));

  adc_seq_top #(.NUM_CH(NB)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(b_irq), .conv_req(b_req),
    .conv_ch(b_ch), .conv_done(1'b0), .conv_data(10'd0));

  int n_cmp = 0, n_bad = 0;

  // converter model and expected results
  int          nlog = 0, lat_force = 0, cnt = 0;
  logic [4:0]  log_ch [256];
  logic [9:0]  exp_val [32], snap_val [32];
  logic        exp_new [32], snap_new [32];
  logic        pend = 0;
  logic [4:0]  pch = 0;
  logic [9:0]  pval = 0;

  initial for (int i = 0; i < 32; i++) begin exp_val[i] = 0; exp_new[i] = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      a_done = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          a_done = 1'b1; a_data = pval;
          exp_val[pch] = pval; exp_new[pch] = 1'b1; pend = 1'b0;
        end else cnt--;
      end
      if (a_req) begin
        pend = 1'b1; pch = a_ch;
        pval = 10'((int'(a_ch) * 37 + nlog * 11) & 1023);
        cnt = (lat_force != 0) ? lat_force : int'($urandom_range(3, 0));
        if (nlog < 256) log_ch[nlog] = a_ch;
        nlog++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sb, logic [7:0] ad, logic [15:0] d);
    @(negedge clk);
    if (sb) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else    begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(bit sb, logic [7:0] ad, output logic [15:0] d);
    @(negedge clk);
    if (sb) begin b_rd = 1; b_addr = ad; end
    else    begin a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
    d = sb ? b_rdata : a_rdata;
  endtask

  task automatic chk_reg(string tag, logic [7:0] ad, logic [15:0] exp);
    logic [15:0] v;
    rd(0, ad, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_ch(string tag, int c);
    logic [15:0] v;
    rd(0, 8'(8'h40 + 2 * c), v);
    chk(tag, v, {exp_new[c], 5'b0, exp_val[c]});
    exp_new[c] = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    logic [15:0] v;
    bit done = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5000 && !done; i++) begin
      rd(0, 8'h02, v);
      if (!v[1]) done = 1;
    end
    chk(tag, 32'(done), 32'd1);
  endtask

  task automatic wait_log(string tag, int n);
    bit ok = 0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk);
      if (nlog >= n) ok = 1;
    end
    chk(tag, 32'(ok), 32'd1);
  endtask

  task automatic snap();
    for (int i = 0; i < 32; i++) begin snap_val[i] = exp_val[i]; snap_new[i] = exp_new[i]; end
  endtask

  task automatic restore();
    for (int i = 0; i < 32; i++) begin exp_val[i] = snap_val[i]; exp_new[i] = snap_new[i]; end
  endtask

  function automatic int popc(logic [31:0] m);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic int nth_set(logic [31:0] m, int n);
    int k = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        if (k == n) return i;
        k++;
      end
    end
    return -1;
  endfunction

  task automatic start(logic [31:0] m, logic [15:0] extra);
    wr(0, 8'h08, m[15:0]);
    wr(0, 8'h0A, m[31:16]);
    wr(0, 8'h02, 16'h0001);
    nlog = 0;
    wr(0, 8'h00, C_EN | C_GO | extra);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] m;
    int p, keep;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 cfg", 8'h00, 16'h0000);
    chk_reg("R1 stat", 8'h02, 16'h0000);
    chk_reg("R1 sel_lo", 8'h08, 16'h0000);
    chk_reg("R1 sel_hi", 8'h0A, 16'h0000);
    chk_reg("R1 data ch0", 8'h40, 16'h0000);
    chk("R1 irq", 32'(a_irq), 0);
    chk("R1 conv_req", 32'(a_req), 0);

    // R2 split mask and width limits
    wr(0, 8'h0A, 16'hFFFF);
    chk_reg("R2 sel_hi masked", 8'h0A, 16'h03FF);
    wr(0, 8'h08, 16'hA5A5);
    chk_reg("R2 sel_lo", 8'h08, 16'hA5A5);
    wr(1, 8'h0A, 16'hFFFF);
    rd(1, 8'h0A, v);
    chk("R2 small sel_hi absent", v, 16'h0000);
    wr(1, 8'h08, 16'hFFFF);
    rd(1, 8'h08, v);
    chk("R2 small sel_lo masked", v, 16'h0FFF);

    // R3 R5 R6 R7 R8 scans over directed and random masks
    for (int k = 0; k < 10; k++) begin
      m = (k == 0) ? 32'h1 : (k == 1) ? (32'h1 << (NA - 1)) : (k == 2) ? FULL_A
        : ($urandom() & FULL_A);
      start(m, C_SCAN | C_IE);
      wait_idle("R3 scan finishes");
      p = popc(m);
      chk("R3 conversion count", 32'(nlog), 32'(p));
      for (int i = 0; i < p && i < 256; i++)
        chk("R3 ascending order", 32'(log_ch[i]), 32'(nth_set(m, i)));
      chk_reg("R7 event after pass", 8'h02, 16'h0001);
      chk("R8 irq with enable", 32'(a_irq), 1);
      for (int i = 0; i < p; i++) chk_ch("R5 data and new flag", nth_set(m, i));
      if (p > 0) chk_ch("R6 new cleared on read", nth_set(m, 0));
    end

    // R7 write-one-to-clear
    wr(0, 8'h02, 16'h0000);
    chk_reg("R7 write 0 keeps event", 8'h02, 16'h0001);
    wr(0, 8'h02, 16'h0001);
    chk_reg("R7 write 1 clears event", 8'h02, 16'h0000);
    chk("R8 irq drops with event", 32'(a_irq), 0);

    // R8 enable off
    start(32'h4, C_SCAN);
    wait_idle("R8 pass finishes");
    chk_reg("R8 event set", 8'h02, 16'h0001);
    chk("R8 irq masked", 32'(a_irq), 0);
    chk_ch("R5 ch2", 2);

    // R4 single channel
    wr(0, 8'h04, 16'd7);
    start(32'h00F0_0003, 16'h0000);
    wait_idle("R4 single finishes");
    chk("R4 one conversion", 32'(nlog), 1);
    chk("R4 channel", 32'(log_ch[0]), 7);
    chk_ch("R4 data ch7", 7);
    wr(0, 8'h04, 16'd30);
    start(32'h1, 16'h0000);
    wait_idle("R4 out of range finishes");
    chk("R4 out of range no conversion", 32'(nlog), 0);
    chk_reg("R4 out of range event", 8'h02, 16'h0001);

    // R9 empty mask
    start(32'h0, C_SCAN);
    wait_idle("R9 finishes");
    chk("R9 no conversion", 32'(nlog), 0);
    chk_reg("R9 event", 8'h02, 16'h0001);

    // R10 repeat, then R11 stop
    lat_force = 8;
    m = ($urandom() & FULL_A) | 32'h0000_0201;
    p = popc(m);
    start(m, C_SCAN | C_REP | C_IE);
    chk_reg("R10 cfg readback", 8'h00, 16'h00D1);
    wait_log("R10 repeats", 2 * p + 1);
    for (int i = 0; i < 2 * p && i < 256; i++)
      chk("R10 repeated order", 32'(log_ch[i]), 32'(nth_set(m, i % p)));
    chk_reg("R10 event while running", 8'h02, 16'h0003);
    snap();
    wr(0, 8'h00, C_EN | C_HALT);
    keep = nlog;
    repeat (40) @(negedge clk);
    restore();
    chk("R11 no request after stop", 32'(nlog), 32'(keep));
    chk_reg("R11 idle after stop", 8'h02, 16'h0001);
    chk_ch("R11 aborted sample not stored", int'(log_ch[keep - 1]));

    // R11 stop before any pass ends leaves event clear
    start(FULL_A, C_SCAN);
    wait_log("R11 running", 3);
    snap();
    wr(0, 8'h00, C_EN | C_SCAN | C_HALT);
    repeat (40) @(negedge clk);
    restore();
    chk_reg("R11 stop no event", 8'h02, 16'h0000);
    chk_ch("R11 aborted channel", int'(log_ch[2]));

    // R11 clearing enable aborts
    start(FULL_A, C_SCAN);
    wait_log("R11 running again", 2);
    snap();
    wr(0, 8'h00, 16'h0000);
    repeat (40) @(negedge clk);
    restore();
    chk_reg("R11 disable aborts", 8'h02, 16'h0000);
    chk_ch("R11 disabled channel", int'(log_ch[1]));

    // R11 start without enable
    lat_force = 0;
    nlog = 0;
    wr(0, 8'h00, C_GO | C_SCAN);
    repeat (10) @(negedge clk);
    chk("R11 start ignored without enable", 32'(nlog), 0);
    chk_reg("R11 still idle", 8'h02, 16'h0000);

    report();
    $finish;
  end

endmodule